// File: doc/BRIEF.md
# Request/Acknowledge Bridge with 8-to-16 Bit Packing

This block joins a byte-wide producer to a halfword-wide consumer whose handshakes do not line up. The producer raises a request and expects an acknowledge in the very next cycle. After that it writes bytes, and it writes another only while a continuation control is high. The consumer wants to see a request, answers it with its own acknowledge, and takes exactly one wide word when a data-ready strobe appears. Neither side drives the continuation or the data-ready control, so the bridge generates both.

The bridge answers the producer by itself and passes the request on to the consumer. It absorbs the consumer's acknowledge and collects bytes into a packing register. It presents a full word only once the consumer has acknowledged. A weighted occupancy counter rises by one step per write and falls by a larger step per read. Any write or read that would take the counter outside its legal range is refused. A sticky fault flag records stimulus that breaks the protocol. The read width must be an integer multiple of the write width.

Top module: `hs_width_bridge`

## Requirements
- R1: A synchronous active-high reset returns the bridge to idle with an empty counter and a cleared packing register. After reset, prodAck, prodMore, consReq, consRdy and errSticky are all 0.
- R2: A prodReq sampled high while idle causes prodAck to be high for exactly the one following cycle.
- R3: consReq is high from the prodAck cycle until the bridge samples consAck high. No new request is taken from the producer until the collected word has been delivered.
- R4: During collection, prodMore is high exactly while one more write fits in the counter range. A write is accepted only in a cycle where prodMore is high.
- R5: The first accepted byte lands in consData bits 7:0 and the second in bits 15:8.
- R6: consRdy is a one-cycle pulse. It is given only when the counter is full and the consumer has acknowledged, and the bridge then returns to idle.
- R7: The counter rises by K/16 per write and falls by K/8 per read, with K = 16. It stays within 0..2, so a read at 0 and a write at 2 are both blocked.
- R8: A prodWrite while prodMore is low, or a consAck while consReq is low, is ignored and leaves the packed data unchanged. Either event sets errSticky, which stays set until reset.
- R9: A prodReq seen outside the idle state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prodReq | input | 1 | Producer request |
| prodAck | output | 1 | Acknowledge generated for the producer |
| prodWrite | input | 1 | Producer byte write strobe |
| prodData | input | 8 | Producer byte |
| prodMore | output | 1 | Generated continuation control for the producer |
| consReq | output | 1 | Request forwarded to the consumer |
| consAck | input | 1 | Consumer acknowledge |
| consRdy | output | 1 | Generated one-cycle data-ready strobe |
| consData | output | 16 | Packed word, valid while consRdy is high |
| errSticky | output | 1 | Sticky protocol fault flag |

## Verification
The bound checker watches, on every cycle, that the occupancy never leaves its range and that prodMore never offers a write into a full buffer. It also checks that a data-ready pulse lasts one cycle, is given only at full occupancy and leaves the counter empty, that an acknowledge always follows a request, and that the fault flag never clears by itself. Byte order within the packed word, the point at which the delayed consumer acknowledge releases the word, and whether stray writes and requests are truly ignored can only be shown by the bench's scenarios. For those, a behavioural queue model predicts every output on every cycle.

// File: rtl/hs_bridge_pkg.sv
package hs_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GRANT,
    ST_FILL,
    ST_DELIVER
  } bridgeState_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } dpStrobe_t;

  // buffer capacity: smallest multiple of the write width covering one read
  function automatic int capacityOf(input int wrW, input int rdW);
    return wrW * ((rdW + wrW - 1) / wrW);
  endfunction

  function automatic int wrStepOf(input int wrW, input int rdW);
    return capacityOf(wrW, rdW) / rdW;
  endfunction

  function automatic int rdStepOf(input int wrW, input int rdW);
    return capacityOf(wrW, rdW) / wrW;
  endfunction

  function automatic int occMaxOf(input int wrW, input int rdW);
    return wrStepOf(wrW, rdW) * rdStepOf(wrW, rdW);
  endfunction

endpackage

// File: rtl/hs_bridge_datapath.sv
module hs_bridge_datapath
  import hs_bridge_pkg::*;
#(
  parameter int WR_W = 8,
  parameter int RD_W = 16,
  localparam int WR_STEP = wrStepOf(WR_W, RD_W),
  localparam int RD_STEP = rdStepOf(WR_W, RD_W),
  localparam int OCC_MAX = occMaxOf(WR_W, RD_W),
  localparam int OCC_W = $clog2(OCC_MAX + 1),
  localparam int WORDS = RD_W / WR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [WR_W-1:0]  wrData,
  output logic [RD_W-1:0]  rdData,
  output logic [OCC_W-1:0] occ,
  output logic             canWrite,
  output logic             canRead,
  output logic             dpFault
);

  logic [OCC_W-1:0] occNext;
  logic [WR_W-1:0]  slots [WORDS];

  assign canWrite = ({1'b0, occ} + (OCC_W+1)'(WR_STEP)) <= (OCC_W+1)'(OCC_MAX);
  assign canRead  = occ >= OCC_W'(RD_STEP);
  assign dpFault  = (strb.wrEn && !canWrite) || (strb.rdEn && !canRead);

  always_comb begin
    occNext = occ;
    if (strb.wrEn && canWrite) occNext = occNext + OCC_W'(WR_STEP);
    if (strb.rdEn && canRead)  occNext = occNext - OCC_W'(RD_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occNext;
  end

  for (genvar g = 0; g < WORDS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (rst)
        slots[g] <= '0;
      else if (strb.wrEn && canWrite && occ == OCC_W'(g * WR_STEP))
        slots[g] <= wrData;
    end
    assign rdData[g*WR_W +: WR_W] = slots[g];
  end

endmodule

// File: rtl/hs_bridge_ctrl.sv
module hs_bridge_ctrl
  import hs_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      prodReq,
  input  logic      prodWrite,
  input  logic      consAck,
  input  logic      canWrite,
  input  logic      canRead,
  input  logic      dpFault,
  output logic      prodAck,
  output logic      prodMore,
  output logic      consReq,
  output logic      consRdy,
  output logic      errSticky,
  output dpStrobe_t strb
);

  bridgeState_t state, stateNext;
  logic ackSeen;

  always_comb begin
    prodAck   = (state == ST_GRANT);
    consReq   = ((state == ST_GRANT) || (state == ST_FILL)) && !ackSeen;
    prodMore  = (state == ST_FILL) && canWrite;
    consRdy   = (state == ST_DELIVER);
    strb.wrEn = prodWrite && prodMore;
    strb.rdEn = (state == ST_DELIVER);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (prodReq) stateNext = ST_GRANT;
      ST_GRANT:   stateNext = ST_FILL;
      ST_FILL:    if (!canWrite && canRead && ackSeen) stateNext = ST_DELIVER;
      ST_DELIVER: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ackSeen   <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_DELIVER)        ackSeen <= 1'b0;
      else if (consAck && consReq)    ackSeen <= 1'b1;
      errSticky <= errSticky || (prodWrite && !prodMore)
                             || (consAck && !consReq) || dpFault;
    end
  end

endmodule

// File: rtl/hs_width_bridge.sv
module hs_width_bridge #(
  parameter int WR_W = 8,
  parameter int RD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prodReq,
  output logic            prodAck,
  input  logic            prodWrite,
  input  logic [WR_W-1:0] prodData,
  output logic            prodMore,
  output logic            consReq,
  input  logic            consAck,
  output logic            consRdy,
  output logic [RD_W-1:0] consData,
  output logic            errSticky
);
  import hs_bridge_pkg::*;

  localparam int OCC_MAX = occMaxOf(WR_W, RD_W);
  localparam int OCC_W = $clog2(OCC_MAX + 1);

  dpStrobe_t        strb;
  logic [OCC_W-1:0] occ;
  logic             canWrite;
  logic             canRead;
  logic             dpFault;

  hs_bridge_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .prodReq   (prodReq),
    .prodWrite (prodWrite),
    .consAck   (consAck),
    .canWrite  (canWrite),
    .canRead   (canRead),
    .dpFault   (dpFault),
    .prodAck   (prodAck),
    .prodMore  (prodMore),
    .consReq   (consReq),
    .consRdy   (consRdy),
    .errSticky (errSticky),
    .strb      (strb)
  );

  hs_bridge_datapath #(.WR_W(WR_W), .RD_W(RD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (prodData),
    .rdData   (consData),
    .occ      (occ),
    .canWrite (canWrite),
    .canRead  (canRead),
    .dpFault  (dpFault)
  );

endmodule

// File: rtl/hs_width_bridge_chk.sv
module hs_width_bridge_chk #(
  parameter int WR_W = 8,
  parameter int RD_W = 16,
  localparam int OCC_MAX = hs_bridge_pkg::occMaxOf(WR_W, RD_W),
  localparam int RD_STEP = hs_bridge_pkg::rdStepOf(WR_W, RD_W),
  localparam int OCC_W = $clog2(OCC_MAX + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             prodReq,
  input logic             prodAck,
  input logic             prodMore,
  input logic             consRdy,
  input logic             errSticky,
  input logic [OCC_W-1:0] occ
);

  // R7
  occ_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(OCC_MAX));

  // R4
  more_not_full_chk: assert property (@(posedge clk) disable iff (rst)
    prodMore |-> (occ < OCC_W'(OCC_MAX)));

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    prodAck |-> $past(prodReq));

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    prodAck |=> !prodAck);

  // R6
  rdy_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    consRdy |-> (occ == OCC_W'(OCC_MAX)) && (occ >= OCC_W'(RD_STEP)));

  // R6
  rdy_drains_chk: assert property (@(posedge clk) disable iff (rst)
    consRdy |=> (occ == '0) && !consRdy);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> errSticky);

endmodule

bind hs_width_bridge hs_width_bridge_chk #(.WR_W(WR_W), .RD_W(RD_W)) chk (
  .clk       (clk),
  .rst       (rst),
  .prodReq   (prodReq),
  .prodAck   (prodAck),
  .prodMore  (prodMore),
  .consRdy   (consRdy),
  .errSticky (errSticky),
  .occ       (occ)
);

// File: tb/hs_width_bridge_test.sv
module hs_width_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prodReq = 1'b0;
  logic        prodWrite = 1'b0;
  logic [7:0]  prodData = '0;
  logic        consAck = 1'b0;
  logic        prodAck, prodMore, consReq, consRdy, errSticky;
  logic [15:0] consData;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int         mPhase = 0;   // 0 idle, 1 answering, 2 collecting, 3 delivering
  logic [7:0] mq[$];
  bit         mAcked = 1'b0;
  bit         mErr = 1'b0;

  always #2 clk = ~clk;

  hs_width_bridge uut (
    .clk(clk), .rst(rst), .prodReq(prodReq), .prodAck(prodAck),
    .prodWrite(prodWrite), .prodData(prodData), .prodMore(prodMore),
    .consReq(consReq), .consAck(consAck), .consRdy(consRdy),
    .consData(consData), .errSticky(errSticky)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit r, input bit req, input bit wr,
                      input logic [7:0] d, input bit ack);
    bit expAck, expReq, expMore, expRdy;
    logic [15:0] expData;
    int nPhase;
    @(negedge clk);
    rst = r; prodReq = req; prodWrite = wr; prodData = d; consAck = ack;
    #1;
    expAck  = (mPhase == 1);
    expReq  = (mPhase == 1 || mPhase == 2) && !mAcked;
    expMore = (mPhase == 2) && (mq.size() < 2);
    expRdy  = (mPhase == 3);
    expData = (mq.size() == 2) ? {mq[1], mq[0]} : 16'h0;
    check(prodAck === expAck, "R2 prodAck", 32'(prodAck), 32'(expAck));
    check(consReq === expReq, "R3 consReq", 32'(consReq), 32'(expReq));
    check(prodMore === expMore, "R4 R7 prodMore", 32'(prodMore), 32'(expMore));
    check(consRdy === expRdy, "R6 R7 consRdy", 32'(consRdy), 32'(expRdy));
    check(errSticky === mErr, "R8 errSticky", 32'(errSticky), 32'(mErr));
    if (expRdy) check(consData === expData, "R5 consData", 32'(consData), 32'(expData));
    nPhase = mPhase;
    case (mPhase)
      0: if (req) nPhase = 1;
      1: nPhase = 2;
      2: if (mq.size() == 2 && mAcked) nPhase = 3;
      default: nPhase = 0;
    endcase
    if ((wr && !expMore) || (ack && !expReq)) mErr = 1'b1;
    if (mPhase == 3) begin
      mq.delete();
      mAcked = 1'b0;
    end else begin
      if (ack && expReq) mAcked = 1'b1;
      if (wr && expMore) mq.push_back(d);
    end
    mPhase = nPhase;
    @(posedge clk);
    if (r) begin
      mPhase = 0; mq.delete(); mAcked = 1'b0; mErr = 1'b0;
    end
  endtask

  // one full transfer; ackAt selects the cycle of the consumer acknowledge
  task automatic transfer(input logic [7:0] lo, input logic [7:0] hi,
                          input int ackAt, input int gap, input bit holdReq);
    tick(0, 1, 0, 8'h00, 0);
    tick(0, holdReq, 0, 8'h00, ackAt == 0);
    for (int i = 0; i < gap; i++) tick(0, holdReq, 0, 8'h00, 0);
    tick(0, holdReq, 1, lo, ackAt == 1);
    for (int i = 0; i < gap; i++) tick(0, holdReq, 0, 8'h00, 0);
    tick(0, holdReq, 1, hi, 0);
    if (ackAt >= 2) begin
      tick(0, holdReq, 0, 8'h00, 0);
      tick(0, holdReq, 0, 8'h00, 1);
    end
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(1, 0, 0, 8'h00, 0);
    tick(1, 0, 0, 8'h00, 0);
    // R1: outputs idle right after reset
    @(negedge clk); #1;
    check({prodAck, prodMore, consReq, consRdy, errSticky} === 5'b0, "R1 reset outputs",
          32'({prodAck, prodMore, consReq, consRdy, errSticky}), 32'h0);

    transfer(8'h34, 8'h12, 0, 0, 0);     // R5 basic packing, ack in answer cycle
    transfer(8'hA5, 8'h5A, 1, 0, 0);     // ack during collection
    transfer(8'hFF, 8'h00, 2, 0, 0);     // R6 ack only after full
    transfer(8'h01, 8'h80, 0, 2, 1);     // R9 request held high, slow writes
    for (int i = 0; i < 24; i++)
      transfer(8'(i * 37 + 3), 8'(i * 91 + 7), i % 3, i % 2, i[2]);

    // R8: write while full is ignored and flagged
    tick(0, 1, 0, 8'h00, 0);
    tick(0, 0, 0, 8'h00, 1);
    tick(0, 0, 1, 8'h11, 0);
    tick(0, 0, 1, 8'h22, 0);
    tick(0, 0, 1, 8'h99, 0);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 8'h00, 0);
    @(negedge clk); #1;
    check(errSticky === 1'b1, "R8 sticky after write while full", 32'(errSticky), 32'h1);

    // R1: reset clears the fault flag
    tick(1, 0, 0, 8'h00, 0);
    // R8: stray write and stray acknowledge in idle
    tick(0, 0, 1, 8'h77, 0);
    tick(0, 0, 0, 8'h00, 1);
    transfer(8'hC3, 8'h3C, 1, 0, 0);
    tick(1, 0, 0, 8'h00, 0);
    transfer(8'h0F, 8'hF0, 0, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule